// File: doc/BRIEF.md
# Circular trace buffer address controller

This block produces the write side of a trace capture memory. Software sets a lower and an upper word address. The block keeps a pointer that always names the next location to be filled. While capture is running, every trace word offered by the encoder is given the pointer's current value as its memory address, together with a one-cycle write strobe. The pointer then moves on by one word.

When the pointer reaches the upper address, one of two things happens. In wrap mode it returns to the lower address and capture goes on. In halt mode it stays on the upper address, raises a full flag and refuses further words until software reloads it.

Two event sources, a FIFO overflow pulse from outside and the memory-full event, each feed a raw status bit. Each bit can be cleared by software. A per-source enable decides whether a raw bit drives the single interrupt line.

Top module: `trace_ring_addr`

## Requirements
- R1: In reset (active-high, synchronous), cur_ptr is 0, mem_we is 0, full is 0, capturing is 0, irq_raw is 2'b00, irq is 0 and fifo_empty is 1.
- R2: A word (word_valid high) is taken only while capturing is 1. Each word taken produces mem_we high for exactly one cycle, one clock after the word. During that cycle mem_addr equals the pointer value from before the word.
- R3: A word taken at an address other than cfg_limit leaves cur_ptr equal to that address plus one.
- R4: With cfg_wrap = 1, a word taken at cfg_limit sets cur_ptr to cfg_base and sets irq_raw bit 1 (memory full).
- R5: With cfg_wrap = 0, a word taken at cfg_limit leaves cur_ptr at cfg_limit and sets full and irq_raw bit 1. No further word is written while full is 1.
- R6: A cmd_rewind pulse loads cur_ptr with cfg_base and clears full. A word offered in the same cycle is dropped.
- R7: An ovf_pulse sets irq_raw bit 0. A 1 on irq_clr[n] clears irq_raw[n]. If a set and a clear of the same bit fall in one cycle, the bit ends up set.
- R8: irq equals the OR over both bits of (irq_raw[n] AND irq_en[n]), where the enable is the value present at the clock edge that updated irq_raw.
- R9: fifo_empty is a registered copy of fifo_empty_i.
- R10: cmd_go sets capturing and cmd_halt clears it. If both arrive in one cycle, capturing ends up 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_base | input | AW | Lower bound (first word) of the buffer |
| cfg_limit | input | AW | Upper bound (last word) of the buffer |
| cfg_wrap | input | 1 | 1: wrap to base at limit, 0: halt at limit |
| cmd_rewind | input | 1 | One-cycle pulse that reloads the pointer with cfg_base |
| cmd_go | input | 1 | One-cycle pulse that starts capture |
| cmd_halt | input | 1 | One-cycle pulse that stops capture |
| word_valid | input | 1 | A trace word is offered this cycle |
| ovf_pulse | input | 1 | FIFO overflow event |
| fifo_empty_i | input | 1 | Live FIFO empty indication |
| irq_en | input | 2 | Interrupt enables (bit 0 overflow, bit 1 full) |
| irq_clr | input | 2 | Write-1-to-clear pulses for irq_raw |
| mem_addr | output | AW | Write address to the trace memory |
| mem_we | output | 1 | Write strobe, one cycle per word |
| cur_ptr | output | AW | Next address to be written |
| capturing | output | 1 | Capture is active |
| full | output | 1 | Halted at the limit in halt mode |
| fifo_empty | output | 1 | Registered FIFO empty status |
| irq_raw | output | 2 | Raw event bits (bit 0 overflow, bit 1 full) |
| irq | output | 1 | Masked interrupt |

## Verification
The bench runs words through the limit in both modes. A design that increments past the limit, or that skips the last word, produces a wrong address in the scoreboard or a wrong pointer afterwards. It then offers an extra word after a halt-mode stop. A design that ignores full would emit an unexpected strobe, which the monitor flags because its queue is empty. A rewind and a word are driven in the same cycle, so a design that lets the word through shows up as a stray strobe. A set and a clear are driven together, as are start and stop, so an inverted priority leaves the wrong value in irq_raw or capturing.

// File: rtl/trp_pkg.sv
package trp_pkg;
  localparam int SRC_N    = 2;
  localparam int SRC_OVF  = 0;
  localparam int SRC_FULL = 1;
endpackage

// File: rtl/trp_ctrl.sv
// Capture on/off state and the registered FIFO empty status.
module trp_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic cmd_go,
  input  logic cmd_halt,
  input  logic fifo_empty_i,
  output logic active,
  output logic empty_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      empty_q <= 1'b1;
    end else begin
      empty_q <= fifo_empty_i;
      if (cmd_halt)    active <= 1'b0;   // stop has priority over start
      else if (cmd_go) active <= 1'b1;
    end
  end
endmodule

// File: rtl/trp_pointer.sv
// Write pointer with wrap or halt at the upper bound.
module trp_pointer #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] limit,
  input  logic          wrap,
  input  logic          rewind,
  input  logic          active,
  input  logic          word_valid,
  output logic [AW-1:0] ptr,
  output logic [AW-1:0] wr_addr,
  output logic          wr_en,
  output logic          full_q,
  output logic          full_evt
);
  logic accept;
  logic at_limit;

  assign at_limit = (ptr == limit);
  assign accept   = word_valid & active & ~full_q & ~rewind;
  assign full_evt = accept & at_limit;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr     <= '0;
      wr_addr <= '0;
      wr_en   <= 1'b0;
      full_q  <= 1'b0;
    end else begin
      wr_en <= accept;
      if (accept) wr_addr <= ptr;
      if (rewind) begin
        ptr    <= base;
        full_q <= 1'b0;
      end else if (accept) begin
        if (at_limit) begin
          if (wrap) ptr    <= base;
          else      full_q <= 1'b1;
        end else begin
          ptr <= ptr + AW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/trp_irq.sv
// Raw / enable / clear event bits and the masked interrupt line.
module trp_irq
  import trp_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [SRC_N-1:0] set,
  input  logic [SRC_N-1:0] clr,
  input  logic [SRC_N-1:0] en,
  output logic [SRC_N-1:0] raw,
  output logic             irq
);
  logic [SRC_N-1:0] raw_d;

  for (genvar i = 0; i < SRC_N; i++) begin : g_src
    assign raw_d[i] = set[i] | (raw[i] & ~clr[i]);   // set wins over clear
    always_ff @(posedge clk) begin
      if (rst) raw[i] <= 1'b0;
      else     raw[i] <= raw_d[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(raw_d & en);
  end
endmodule

// File: rtl/trace_ring_addr.sv
module trace_ring_addr
  import trp_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AW-1:0]    cfg_base,
  input  logic [AW-1:0]    cfg_limit,
  input  logic             cfg_wrap,
  input  logic             cmd_rewind,
  input  logic             cmd_go,
  input  logic             cmd_halt,
  input  logic             word_valid,
  input  logic             ovf_pulse,
  input  logic             fifo_empty_i,
  input  logic [SRC_N-1:0] irq_en,
  input  logic [SRC_N-1:0] irq_clr,
  output logic [AW-1:0]    mem_addr,
  output logic             mem_we,
  output logic [AW-1:0]    cur_ptr,
  output logic             capturing,
  output logic             full,
  output logic             fifo_empty,
  output logic [SRC_N-1:0] irq_raw,
  output logic             irq
);
  logic             full_evt;
  logic [SRC_N-1:0] evt;

  trp_ctrl u_ctrl (
    .clk(clk), .rst(rst), .cmd_go(cmd_go), .cmd_halt(cmd_halt),
    .fifo_empty_i(fifo_empty_i), .active(capturing), .empty_q(fifo_empty)
  );

  trp_pointer #(.AW(AW)) u_ptr (
    .clk(clk), .rst(rst), .base(cfg_base), .limit(cfg_limit), .wrap(cfg_wrap),
    .rewind(cmd_rewind), .active(capturing), .word_valid(word_valid),
    .ptr(cur_ptr), .wr_addr(mem_addr), .wr_en(mem_we), .full_q(full),
    .full_evt(full_evt)
  );

  always_comb begin
    evt           = '0;
    evt[SRC_OVF]  = ovf_pulse;
    evt[SRC_FULL] = full_evt;
  end

  trp_irq u_irq (
    .clk(clk), .rst(rst), .set(evt), .clr(irq_clr), .en(irq_en),
    .raw(irq_raw), .irq(irq)
  );
endmodule

// File: rtl/trp_chk.sv
module trp_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] cfg_base,
  input logic [AW-1:0] cfg_limit,
  input logic          cmd_rewind,
  input logic          ovf_pulse,
  input logic [1:0]    irq_en,
  input logic [AW-1:0] mem_addr,
  input logic          mem_we,
  input logic [AW-1:0] cur_ptr,
  input logic          capturing,
  input logic          full,
  input logic [1:0]    irq_raw,
  input logic          irq
);
  // R2
  we_needs_active_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> $past(capturing));
  // R3
  ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_we && mem_addr != $past(cfg_limit)) |-> cur_ptr == mem_addr + AW'(1));
  // R5
  full_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    (full && $past(full)) |-> !mem_we);
  // R6
  rewind_load_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(cmd_rewind) && !$past(rst)) |-> (cur_ptr == $past(cfg_base) && !full && !mem_we));
  // R7
  ovf_raw_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(ovf_pulse) && !$past(rst)) |-> irq_raw[0]);
  // R8
  irq_mask_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> irq == |(irq_raw & $past(irq_en)));
endmodule

bind trace_ring_addr trp_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .cfg_base(cfg_base), .cfg_limit(cfg_limit),
  .cmd_rewind(cmd_rewind), .ovf_pulse(ovf_pulse), .irq_en(irq_en),
  .mem_addr(mem_addr), .mem_we(mem_we), .cur_ptr(cur_ptr),
  .capturing(capturing), .full(full), .irq_raw(irq_raw), .irq(irq)
);

// File: tb/tb_trace_ring_addr.sv
module tb_trace_ring_addr;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] cfg_base = '0, cfg_limit = '1;
  logic          cfg_wrap = 1'b1;
  logic          cmd_rewind = 0, cmd_go = 0, cmd_halt = 0;
  logic          word_valid = 0, ovf_pulse = 0, fifo_empty_i = 0;
  logic [1:0]    irq_en = 0, irq_clr = 0;
  logic [AW-1:0] mem_addr, cur_ptr;
  logic          mem_we, capturing, full, fifo_empty, irq;
  logic [1:0]    irq_raw;

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  logic [AW-1:0] exp_q[$];
  logic [AW-1:0] m_ptr;
  bit m_active, m_full, m_wrap;
  logic prev_we = 0;

  always #10 clk = ~clk;   // 50 MHz

  trace_ring_addr #(.AW(AW)) dut (.*);

  task automatic check(string req, logic [AW-1:0] act, logic [AW-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Driver: offers one word and pushes the expected address if it will be taken.
  task automatic send_word(bit with_rewind = 0);
    @(negedge clk);
    word_valid = 1;
    cmd_rewind = with_rewind;
    if (m_active && !m_full && !with_rewind) begin
      exp_q.push_back(m_ptr);
      if (m_ptr == cfg_limit) begin
        if (m_wrap) m_ptr = cfg_base; else m_full = 1;
      end else m_ptr = m_ptr + 1;
    end
    if (with_rewind) begin m_ptr = cfg_base; m_full = 0; end
    @(negedge clk);
    word_valid = 0;
    cmd_rewind = 0;
  endtask

  task automatic rewind();
    @(negedge clk); cmd_rewind = 1; m_ptr = cfg_base; m_full = 0;
    @(negedge clk); cmd_rewind = 0;
  endtask

  // Monitor: each strobe pops one expected address (R2).
  always @(negedge clk) begin
    if (!rst && mem_we) begin
      if (prev_we) check("R2 strobe width", 1, 0);
      if (exp_q.size() == 0) check("R2 unexpected write", mem_addr, 'x);
      else check("R2 write address", mem_addr, exp_q.pop_front());
    end
    prev_we = mem_we;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    m_ptr = 0; m_active = 0; m_full = 0; m_wrap = 1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 ptr", cur_ptr, 0);
    check("R1 we", mem_we, 0);
    check("R1 raw", irq_raw, 0);
    check("R1 irq", irq, 0);
    check("R1 full", full, 0);
    check("R1 capturing", capturing, 0);
    check("R1 fifo_empty", fifo_empty, 1);
    rst = 0;

    // R2 word ignored before capture starts
    send_word();
    check("R2 idle ptr", cur_ptr, 0);
    check("R2 idle we", mem_we, 0);

    // R6 rewind to new base
    cfg_base = 32'h100; cfg_limit = 32'h103; cfg_wrap = 1; m_wrap = 1;
    rewind();
    check("R6 reload", cur_ptr, 32'h100);

    // R10 start
    @(negedge clk); cmd_go = 1; m_active = 1;
    @(negedge clk); cmd_go = 0;
    check("R10 go", capturing, 1);

    // R3 / R4 loop mode
    send_word(); check("R3 ptr", cur_ptr, 32'h101);
    send_word(); check("R3 ptr", cur_ptr, 32'h102);
    send_word(); check("R3 ptr", cur_ptr, 32'h103);
    send_word(); check("R4 wrap ptr", cur_ptr, 32'h100);
    check("R4 raw full", irq_raw, 2'b10);
    check("R8 masked", irq, 0);

    // R8 enable, R7 clear
    @(negedge clk); irq_en = 2'b10;
    @(negedge clk);
    check("R8 enabled irq", irq, 1);
    irq_clr = 2'b10;
    @(negedge clk); irq_clr = 0;
    check("R7 cleared", irq_raw, 0);
    check("R8 irq drops", irq, 0);

    // R5 halt mode
    cfg_wrap = 0; m_wrap = 0;
    rewind();
    for (int i = 0; i < 5; i++) send_word();
    check("R5 full", full, 1);
    check("R5 ptr at limit", cur_ptr, 32'h103);
    check("R5 raw", irq_raw[1], 1);

    // R6 rewind with a word in the same cycle
    send_word(1);
    check("R6 full cleared", full, 0);
    check("R6 ptr", cur_ptr, 32'h100);
    check("R6 word dropped", mem_we, 0);

    // R7 overflow, clear, set-beats-clear
    @(negedge clk); irq_clr = 2'b11;
    @(negedge clk); irq_clr = 0; ovf_pulse = 1;
    @(negedge clk); ovf_pulse = 0;
    check("R7 ovf set", irq_raw, 2'b01);
    irq_en = 2'b01;
    @(negedge clk);
    check("R8 ovf irq", irq, 1);
    irq_clr = 2'b01; ovf_pulse = 1;
    @(negedge clk); irq_clr = 0; ovf_pulse = 0;
    check("R7 set wins", irq_raw[0], 1);

    // R10 stop beats start, then words ignored
    @(negedge clk); cmd_go = 1; cmd_halt = 1; m_active = 0;
    @(negedge clk); cmd_go = 0; cmd_halt = 0;
    check("R10 stop wins", capturing, 0);
    send_word();
    check("R2 stopped ptr", cur_ptr, 32'h100);
    check("R2 stopped we", mem_we, 0);

    // R9 fifo empty copy
    @(negedge clk); fifo_empty_i = 1;
    @(negedge clk); check("R9 empty high", fifo_empty, 1);
    fifo_empty_i = 0;
    @(negedge clk); check("R9 empty low", fifo_empty, 0);

    repeat (3) @(negedge clk);
    check("R2 all writes seen", exp_q.size(), 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule